// File: doc/BRIEF.md
# Memory Bus Responder

This block is the storage side of a pulse-driven request/acknowledge memory bus. It holds a parameterized main word array and a separate 16-word fast store. A processor opens a transaction with a one-cycle read request, write request, or both together, and supplies an address and a fast-store select bit. The responder answers a populated address with a one-cycle address acknowledge. It then either returns data or waits for the write data.

The two kinds of completion are deliberately asymmetric. A read finishes on its own: one cycle after the acknowledge, the responder raises a read-restart pulse with the stored word on the data output. A write commits nothing at acknowledge time. The responder waits until the processor sends a write-restart pulse with the word, and only then updates the addressed cell. When read and write are requested together, the responder performs a read-pause-write: the old word is returned first, and the cell is then written when write restart arrives.

Main-store addresses at or above the populated size get no response at all, so the processor's own timeout detects the missing memory. Only one transaction is open at a time. Requests and restarts that arrive in the wrong phase are dropped.

Top module: `membus_responder`

## Requirements
- R1: While reset is low, and after its release, addr_ack and rd_restart are 0 and rd_data is all zeros.
- R2: A read or write request sampled while idle, to a populated address, produces addr_ack high for exactly one cycle, in the cycle after the request was sampled.
- R3: For a read, rd_restart is high for exactly one cycle, in the cycle after addr_ack. In that cycle rd_data holds the addressed word, and rd_data keeps that value until the next rd_restart.
- R4: With fast_sel = 1 the target is the 16-word fast store, indexed by addr[3:0], with the higher address bits ignored. With fast_sel = 0 the target is the main store, indexed by addr[7:0] at the default size. The two stores are separate.
- R5: A write request stores nothing by itself. The word on wr_data is stored at the clock edge where wr_restart is sampled high while the write is pending.
- R6: With fast_sel = 0 and addr at or above MAIN_WORDS (256 by default), the request gets no addr_ack and no rd_restart, and a following wr_restart writes nothing.
- R7: A request sampled while a transaction is still open (the acknowledge cycle, or a pending write) is ignored: no acknowledge follows it and no stored word changes.
- R8: A wr_restart sampled while no write is pending leaves every stored word unchanged.
- R9: A request with both rd_req and wr_req set returns the old word with rd_restart, and then stores the word carried by the next wr_restart.
- R10: A write-only request never raises rd_restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | One-cycle read request |
| wr_req | input | 1 | One-cycle write request |
| fast_sel | input | 1 | 1 selects the fast store, 0 the main store |
| addr | input | ADDR_W | Word address, sampled with the request |
| wr_restart | input | 1 | One-cycle pulse that carries write data |
| wr_data | input | WORD_W | Word stored on wr_restart |
| addr_ack | output | 1 | One-cycle address acknowledge |
| rd_restart | output | 1 | One-cycle read completion pulse |
| rd_data | output | WORD_W | Word returned by the last read |

## Verification
Every result has a fixed position in time, counted from the rising edge that samples a request. addr_ack is due in the cycle right after that edge. rd_restart and the new rd_data are due one cycle later. A written word becomes visible only through a read issued after the wr_restart edge. The bench drives inputs and samples outputs on falling edges. It therefore checks each pulse in its due cycle and again in the cycle after, to confirm the pulse lasts only one cycle. It sweeps every main and fast word and every unpopulated address, then re-reads all of memory to prove that dropped requests and stray restarts changed nothing.

// File: rtl/membus_pkg.sv
// Shared constants and types for the memory bus responder.
package membus_pkg;
    localparam int WORD_BITS  = 36;
    localparam int FAST_DEPTH = 16;

    // Transaction phase of the responder.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK     = 2'd1,
        ST_WAIT_WR = 2'd2
    } mb_state_e;
endpackage

// File: rtl/mb_word_store.sv
// Word array with one shared index: synchronous write, combinational read.
// Assumes idx < DEPTH. Contents are not reset; the bus writes before it reads.
module mb_word_store #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 36,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Commit one word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
    end

    // Present the indexed word continuously.
    assign rdata = cells[idx];
endmodule

// File: rtl/mb_addr_decode.sv
// Decides whether a requested address is populated and derives the cell index.
// Fast-store addresses always exist; main addresses exist below MAIN_DEPTH.
// Assumes MAIN_DEPTH <= 2**ADDR_W and both depths need no more than ADDR_W bits.
module mb_addr_decode #(
    parameter  int ADDR_W     = 10,
    parameter  int MAIN_DEPTH = 256,
    parameter  int FAST_DEPTH = 16,
    localparam int MAIN_IW    = $clog2(MAIN_DEPTH),
    localparam int FAST_IW    = $clog2(FAST_DEPTH),
    localparam int IDX_W      = (MAIN_IW > FAST_IW) ? MAIN_IW : FAST_IW
) (
    input  logic              fast_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              present,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] MAIN_LIMIT = (ADDR_W+1)'(MAIN_DEPTH);

    // Flag populated addresses; an unpopulated one gets no acknowledge.
    always_comb begin
        present = fast_sel || ({1'b0, addr} < MAIN_LIMIT);
    end

    // Keep only the bits either store can use.
    assign idx = addr[IDX_W-1:0];
endmodule

// File: rtl/mb_sequencer.sv
// Transaction sequencer: accepts one request at a time, acknowledges it,
// completes reads by itself and holds writes until the write-restart pulse.
// Assumes requests and restarts are single-cycle pulses.
module mb_sequencer
    import membus_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             req_present,
    input  logic             req_fast,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             wr_restart,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] cell_rdata,
    output logic             addr_ack,
    output logic             rd_restart,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             sel_fast,
    output logic [IDX_W-1:0] sel_idx,
    output logic             main_we,
    output logic             fast_we,
    output logic [WIDTH-1:0] cell_wdata
);
    mb_state_e        state_q, state_d;
    logic             lat_rd_q, lat_wr_q;
    logic             ack_q, rs_q;
    logic [WIDTH-1:0] data_q;
    logic             accept, commit, finish_rd;

    // Qualify incoming pulses by transaction phase.
    always_comb begin
        accept    = (state_q == ST_IDLE) && (rd_req || wr_req) && req_present;
        commit    = (state_q == ST_WAIT_WR) && wr_restart;
        finish_rd = (state_q == ST_ACK) && lat_rd_q;
    end

    // Next phase of the open transaction.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (accept) state_d = ST_ACK;
            ST_ACK:     state_d = lat_wr_q ? ST_WAIT_WR : ST_IDLE;
            ST_WAIT_WR: if (wr_restart) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Phase, latched request and output pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lat_rd_q <= 1'b0;
            lat_wr_q <= 1'b0;
            sel_fast <= 1'b0;
            sel_idx  <= '0;
            ack_q    <= 1'b0;
            rs_q     <= 1'b0;
            data_q   <= '0;
        end else begin
            state_q <= state_d;
            ack_q   <= accept;
            rs_q    <= finish_rd;
            if (accept) begin
                lat_rd_q <= rd_req;
                lat_wr_q <= wr_req;
                sel_fast <= req_fast;
                sel_idx  <= req_idx;
            end
            if (finish_rd) begin
                data_q <= cell_rdata;
            end
        end
    end

    // Route write strobes to the selected store.
    always_comb begin
        main_we    = commit && !sel_fast;
        fast_we    = commit && sel_fast;
        cell_wdata = wr_data;
    end

    assign addr_ack   = ack_q;
    assign rd_restart = rs_q;
    assign rd_data    = data_q;
    assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/membus_responder.sv
// Memory-side responder of the request/acknowledge bus. It holds a main store
// and a 16-word fast store, acknowledges populated addresses, returns read
// data one cycle after the acknowledge and commits writes on write restart.
// Assumes a single outstanding transaction and pulse-shaped requests.
module membus_responder
    import membus_pkg::*;
#(
    parameter  int ADDR_W     = 10,
    parameter  int MAIN_WORDS = 256,
    parameter  int WORD_W     = WORD_BITS,
    localparam int MAIN_IW    = $clog2(MAIN_WORDS),
    localparam int FAST_IW    = $clog2(FAST_DEPTH),
    localparam int IDX_W      = (MAIN_IW > FAST_IW) ? MAIN_IW : FAST_IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              fast_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_restart,
    input  logic [WORD_W-1:0] wr_data,
    output logic              addr_ack,
    output logic              rd_restart,
    output logic [WORD_W-1:0] rd_data
);
    logic              req_present;
    logic [IDX_W-1:0]  req_idx;
    logic              seq_busy;
    logic              sel_fast;
    logic [IDX_W-1:0]  sel_idx;
    logic              main_we, fast_we;
    logic [WORD_W-1:0] cell_wdata, cell_rdata;
    logic [WORD_W-1:0] main_rdata, fast_rdata;

    mb_addr_decode #(
        .ADDR_W    (ADDR_W),
        .MAIN_DEPTH(MAIN_WORDS),
        .FAST_DEPTH(FAST_DEPTH)
    ) u_decode (
        .fast_sel(fast_sel),
        .addr    (addr),
        .present (req_present),
        .idx     (req_idx)
    );

    mb_sequencer #(
        .WIDTH(WORD_W),
        .IDX_W(IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .req_present(req_present),
        .req_fast   (fast_sel),
        .req_idx    (req_idx),
        .wr_restart (wr_restart),
        .wr_data    (wr_data),
        .cell_rdata (cell_rdata),
        .addr_ack   (addr_ack),
        .rd_restart (rd_restart),
        .rd_data    (rd_data),
        .busy       (seq_busy),
        .sel_fast   (sel_fast),
        .sel_idx    (sel_idx),
        .main_we    (main_we),
        .fast_we    (fast_we),
        .cell_wdata (cell_wdata)
    );

    mb_word_store #(
        .DEPTH(MAIN_WORDS),
        .WIDTH(WORD_W)
    ) u_main (
        .clk  (clk),
        .we   (main_we),
        .idx  (sel_idx[MAIN_IW-1:0]),
        .wdata(cell_wdata),
        .rdata(main_rdata)
    );

    mb_word_store #(
        .DEPTH(FAST_DEPTH),
        .WIDTH(WORD_W)
    ) u_fast (
        .clk  (clk),
        .we   (fast_we),
        .idx  (sel_idx[FAST_IW-1:0]),
        .wdata(cell_wdata),
        .rdata(fast_rdata)
    );

    // Pick the store named by the latched select bit.
    always_comb begin
        cell_rdata = sel_fast ? fast_rdata : main_rdata;
    end
endmodule

// File: rtl/membus_responder_chk.sv
// Protocol checker for the memory bus responder, attached by bind.
// Assumes it sees the top-level ports plus the sequencer busy flag.
module membus_responder_chk #(
    parameter int ADDR_W     = 10,
    parameter int MAIN_WORDS = 256,
    parameter int WORD_W     = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              wr_req,
    input logic              fast_sel,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_ack,
    input logic              rd_restart,
    input logic [WORD_W-1:0] rd_data,
    input logic              busy
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MAIN_WORDS);

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |=> !addr_ack);

    p_ack_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> $past(rd_req || wr_req));

    p_restart_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_restart |-> $past(addr_ack));

    p_restart_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_restart |=> !rd_restart);

    p_data_on_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> rd_restart);

    p_absent_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (rd_req || wr_req) && !fast_sel && ({1'b0, addr} >= LIMIT))
        |=> !addr_ack);

    p_busy_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (rd_req || wr_req)) |=> !addr_ack);
endmodule

bind membus_responder membus_responder_chk #(
    .ADDR_W    (ADDR_W),
    .MAIN_WORDS(MAIN_WORDS),
    .WORD_W    (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .fast_sel  (fast_sel),
    .addr      (addr),
    .addr_ack  (addr_ack),
    .rd_restart(rd_restart),
    .rd_data   (rd_data),
    .busy      (seq_busy)
);

// File: tb/test_membus_responder.sv
// Self-checking bench: full sweeps of both stores and of every unpopulated
// address, plus phase-violation and read-pause-write cases.
module test_membus_responder;
    localparam int AW = 10;
    localparam int MW = 256;
    localparam int FW = 16;
    localparam int W  = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0, wr_req = 1'b0, fast_sel = 1'b0, wr_restart = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          addr_ack, rd_restart;
    logic [W-1:0]  rd_data;

    int n_checks = 0;
    int n_errs   = 0;
    logic [W-1:0] main_exp [MW];
    logic [W-1:0] fast_exp [FW];

    always #4 clk = ~clk;

    membus_responder i_membus_responder (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .fast_sel(fast_sel), .addr(addr), .wr_restart(wr_restart),
        .wr_data(wr_data), .addr_ack(addr_ack), .rd_restart(rd_restart),
        .rd_data(rd_data)
    );

    function automatic logic [W-1:0] main_pat(int a, int k);
        return (W'(a) * W'(4099) + W'(k)) ^ W'(36'h5A5A5A5A5);
    endfunction

    function automatic logic [W-1:0] fast_pat(int a, int k);
        return (W'(a) * W'(65537) + W'(k)) ^ W'(36'hC3C3C3C3C);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic sel, input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
        fast_sel = sel; addr = a; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk({tag, " R2 ack"}, W'(addr_ack), W'(1));
        chk({tag, " R3 early restart"}, W'(rd_restart), W'(0));
        @(negedge clk);
        chk({tag, " R2 ack width"}, W'(addr_ack), W'(0));
        chk({tag, " R3 restart"}, W'(rd_restart), W'(1));
        chk({tag, " R3 data"}, rd_data, exp);
        @(negedge clk);
        chk({tag, " R3 restart width"}, W'(rd_restart), W'(0));
        chk({tag, " R3 data held"}, rd_data, exp);
    endtask

    task automatic bus_write(input logic sel, input logic [AW-1:0] a, input logic [W-1:0] d);
        fast_sel = sel; addr = a; wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
        chk("R2 write ack", W'(addr_ack), W'(1));
        @(negedge clk);
        chk("R10 no restart on write", W'(rd_restart), W'(0));
        chk("R2 write ack width", W'(addr_ack), W'(0));
        wr_restart = 1'b1; wr_data = d;
        @(negedge clk); wr_restart = 1'b0; wr_data = '0;
        if (sel) fast_exp[a[3:0]] = d; else main_exp[a[7:0]] = d;
    endtask

    task automatic probe_absent(input logic [AW-1:0] a, input logic as_write);
        fast_sel = 1'b0; addr = a;
        if (as_write) wr_req = 1'b1; else rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; wr_req = 1'b0;
        chk("R6 no ack", W'(addr_ack), W'(0));
        @(negedge clk);
        chk("R6 no ack late", W'(addr_ack), W'(0));
        chk("R6 no restart", W'(rd_restart), W'(0));
        if (as_write) begin
            wr_restart = 1'b1; wr_data = ~main_exp[a[7:0]];
            @(negedge clk); wr_restart = 1'b0; wr_data = '0;
        end
    endtask

    task automatic reread_all(input string tag);
        for (int a = 0; a < MW; a++) bus_read(1'b0, AW'(a), main_exp[a], tag);
        for (int a = 0; a < FW; a++) bus_read(1'b1, AW'(a), fast_exp[a], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset
        chk("R1 ack in reset", W'(addr_ack), W'(0));
        chk("R1 restart in reset", W'(rd_restart), W'(0));
        chk("R1 data in reset", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack after reset", W'(addr_ack), W'(0));
        chk("R1 data after reset", rd_data, '0);

        // R4/R5: fill both stores, then read everything back
        for (int a = 0; a < MW; a++) bus_write(1'b0, AW'(a), main_pat(a, 0));
        for (int a = 0; a < FW; a++) bus_write(1'b1, AW'(a), fast_pat(a, 0));
        reread_all("R4 sweep");

        // R4: fast store ignores upper address bits, even above main range
        for (int a = 0; a < FW; a++)
            bus_read(1'b1, AW'(10'h3F0 | a), fast_exp[a], "R4 fast alias");
        bus_write(1'b1, AW'(10'h2A5), fast_pat(5, 7));
        bus_read(1'b1, AW'(5), fast_pat(5, 7), "R4 fast high write");
        bus_read(1'b0, AW'(5), main_exp[5], "R4 main untouched");

        // R6: every unpopulated main address stays silent
        for (int a = MW; a < (1 << AW); a++) probe_absent(AW'(a), a[0]);
        reread_all("R6 after absent");

        // R7: request while a write is pending
        fast_sel = 1'b0; addr = AW'(5); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
        chk("R7 first ack", W'(addr_ack), W'(1));
        addr = AW'(6); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
        chk("R7 busy ack", W'(addr_ack), W'(0));
        @(negedge clk);
        chk("R7 busy ack late", W'(addr_ack), W'(0));
        chk("R7 busy restart", W'(rd_restart), W'(0));
        wr_restart = 1'b1; wr_data = main_pat(5, 9);
        @(negedge clk); wr_restart = 1'b0; main_exp[5] = main_pat(5, 9);
        bus_read(1'b0, AW'(5), main_exp[5], "R7 pending write landed");
        bus_read(1'b0, AW'(6), main_exp[6], "R7 ignored write");

        // R7: request during the acknowledge cycle of a read
        fast_sel = 1'b0; addr = AW'(7); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk("R7 read ack", W'(addr_ack), W'(1));
        addr = AW'(8); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
        chk("R7 read restart", W'(rd_restart), W'(1));
        chk("R7 read data", rd_data, main_exp[7]);
        chk("R7 second ack", W'(addr_ack), W'(0));
        @(negedge clk);
        chk("R7 second ack late", W'(addr_ack), W'(0));

        // R8: stray write restart while idle
        wr_restart = 1'b1; wr_data = '1;
        @(negedge clk); wr_restart = 1'b0; wr_data = '0;
        bus_read(1'b0, AW'(7), main_exp[7], "R8 stray restart");
        bus_read(1'b0, AW'(8), main_exp[8], "R8 stray restart");

        // R9: read-pause-write on both stores
        for (int s = 0; s < 2; s++) begin
            logic [W-1:0] old_w, new_w;
            fast_sel = s[0]; addr = AW'(20 + s);
            old_w = s[0] ? fast_exp[4'(20 + s)] : main_exp[20 + s];
            new_w = ~old_w;
            rd_req = 1'b1; wr_req = 1'b1;
            @(negedge clk); rd_req = 1'b0; wr_req = 1'b0;
            chk("R9 ack", W'(addr_ack), W'(1));
            @(negedge clk);
            chk("R9 restart", W'(rd_restart), W'(1));
            chk("R9 old data", rd_data, old_w);
            wr_restart = 1'b1; wr_data = new_w;
            @(negedge clk); wr_restart = 1'b0; wr_data = '0;
            chk("R9 restart width", W'(rd_restart), W'(0));
            if (s[0]) fast_exp[4'(20 + s)] = new_w; else main_exp[20 + s] = new_w;
        end
        reread_all("R9 final");

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule